// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error-Tagged Receive Queue

This block turns an asynchronous serial input line into a queue of received characters. It oversamples the line with a 16x enable tick supplied from outside. A falling edge starts a frame, and the start bit is confirmed at its middle. Data bits then arrive least significant first. The word length can be 5, 6, 7 or 8 bits, and a parity bit may follow, checked for even or odd sense. The frame ends with one stop bit.

Each completed character is pushed into a 16-entry queue as a 12-bit word. The word holds the data together with four error tags: overrun, break, parity and framing. The consumer reads the oldest word from a first-word-fall-through read port and pops it with a one-cycle read strobe. It watches the queue-empty and queue-full flags. A sticky 4-bit error summary gathers every error seen, and a one-cycle clear strobe clears it.

The frame engine is a state machine with six states:
- IDLE: waits for the line to go low on a tick, then moves to START.
- START: counts eight ticks. If the line is high again it returns to IDLE as a false start; otherwise it moves to DATA.
- DATA: samples one bit every 16 ticks. After the last bit it moves to PARITY when parity is enabled, otherwise to STOP.
- PARITY: samples the parity bit, then moves to STOP.
- STOP: samples the stop bit and emits the character. If the line was low at every sample, stop bit included, it moves to BREAK_WAIT; otherwise it returns to IDLE.
- BREAK_WAIT: returns to IDLE once the line is high again.

Top module: `uart_rx_tagged`

## Requirements
- R1: A queue entry is 12 bits: bit 11 overrun, bit 10 break, bit 9 parity error, bit 8 framing error, bits 7..0 data.
- R2: `rx_empty` is 1 exactly when no entry is held. `rx_full` is 1 exactly when all 16 entries are held.
- R3: A low level is accepted as a start bit only if the line is still low 8 ticks after the edge was seen. A shorter low pulse stores nothing.
- R4: `cfg_len` selects the word length: 0=5, 1=6, 2=7, 3=8 bits. Bits are received LSB first, and the unused upper data bits of the entry read 0.
- R5: When `cfg_par_en`=1, a parity bit follows the data. With `cfg_par_odd`=0 the data plus parity must hold an even number of ones; with 1, an odd number. A mismatch sets entry bit 9.
- R6: A stop bit sampled low sets entry bit 8, unless the frame is a break.
- R7: If every sampled bit of a frame, stop bit included, is low, one entry with data 0 and only bit 10 set is stored. No further frame starts until the line has returned high.
- R8: A frame that completes while 16 entries are held and no pop occurs in that cycle is discarded. Bit 11 is then set on the newest stored entry. After 17 frames with no reads, 16 entries are held and `rx_full`=1.
- R9: `err_sticky` bit 3=overrun, bit 2=break, bit 1=parity, bit 0=framing. Each bit is set by the matching event on any completed frame and stays set until cleared.
- R10: A one-cycle `err_clr` pulse clears `err_sticky`, except for bits whose events occur in that same cycle.
- R11: Entries are read in arrival order. `rd_data` shows the oldest entry, and `rd_en` removes it. A pop while the queue is empty has no effect, and `rd_data` reads 0 when empty.
- R12: After reset the queue is empty, `rx_full`=0, `err_sticky`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| rx_in | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Word length select (0..3 = 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| rd_en | input | 1 | Pop the oldest entry |
| err_clr | input | 1 | Clear the sticky error summary |
| rd_data | output | 12 | Oldest entry: error tags and data |
| rx_empty | output | 1 | Queue holds no entry |
| rx_full | output | 1 | Queue holds 16 entries |
| err_sticky | output | 4 | Sticky error summary |

## Verification
The bench builds the block with its default parameters: a 16-entry queue and a two-stage input synchronizer. The tick is driven on every second clock, so one bit lasts 32 clocks and the enable gating is exercised rather than bypassed. With a depth of 16, the seventeen-frame overrun case, the full flag and the tag placed on the newest entry can all be reached in a few thousand cycles. Every word length, both parity senses, the framing and break paths, and the false-start filter are each driven in a dedicated scenario.

// File: rtl/uart_rx_tagged_pkg.sv
package uart_rx_tagged_pkg;

    // Oversampling factor and confirmation point of the start bit.
    localparam int OVS      = 16;
    localparam int MID_TICK = OVS / 2 - 1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP,
        S_BREAK_WAIT
    } rx_state_e;

    // Queue entry, MSB first: overrun, break, parity, framing, data.
    typedef struct packed {
        logic       oe;
        logic       be;
        logic       pe;
        logic       fe;
        logic [7:0] data;
    } rx_entry_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], din};
    end

    assign dout = sr[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_tagged_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rx,
    input  logic [1:0] cfg_len,
    input  logic      cfg_par_en,
    input  logic      cfg_par_odd,
    output logic      push,
    output rx_entry_t entry
);
    localparam int CW = $clog2(OVS);

    rx_state_e       state, nxt;
    logic [CW-1:0]   tcnt;
    logic [2:0]      bidx;
    logic [7:0]      shreg;
    logic            par_bit;
    logic            all_low;
    logic [2:0]      last_idx;
    logic            mid_pt;
    logic            bit_pt;

    assign last_idx = 3'd4 + {1'b0, cfg_len};
    assign mid_pt   = tick && (tcnt == CW'(MID_TICK));
    assign bit_pt   = tick && (tcnt == CW'(OVS - 1));

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:       if (tick && !rx) nxt = S_START;
            S_START:      if (mid_pt) nxt = rx ? S_IDLE : S_DATA;
            S_DATA:       if (bit_pt && bidx == last_idx)
                              nxt = cfg_par_en ? S_PARITY : S_STOP;
            S_PARITY:     if (bit_pt) nxt = S_STOP;
            S_STOP:       if (bit_pt) nxt = (all_low && !rx) ? S_BREAK_WAIT : S_IDLE;
            S_BREAK_WAIT: if (rx) nxt = S_IDLE;
            default:      nxt = S_IDLE;
        endcase
    end

    // Datapath and outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt    <= '0;
            bidx    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            all_low <= 1'b0;
            push    <= 1'b0;
            entry   <= '0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                if (state == S_IDLE || state == S_BREAK_WAIT || (state == S_START && mid_pt))
                    tcnt <= '0;
                else
                    tcnt <= tcnt + 1'b1;
            end
            unique case (state)
                S_START: if (mid_pt) begin
                    shreg   <= '0;
                    bidx    <= '0;
                    all_low <= 1'b1;
                end
                S_DATA: if (bit_pt) begin
                    shreg[bidx] <= rx;
                    bidx        <= bidx + 1'b1;
                    if (rx) all_low <= 1'b0;
                end
                S_PARITY: if (bit_pt) begin
                    par_bit <= rx;
                    if (rx) all_low <= 1'b0;
                end
                S_STOP: if (bit_pt) begin
                    push <= 1'b1;
                    if (all_low && !rx) begin
                        entry <= '{oe: 1'b0, be: 1'b1, pe: 1'b0, fe: 1'b0, data: 8'h00};
                    end else begin
                        entry <= '{oe: 1'b0, be: 1'b0,
                                   pe: cfg_par_en && ((^shreg ^ par_bit) != cfg_par_odd),
                                   fe: !rx, data: shreg};
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_rx_tagged_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t push_entry,
    input  logic      pop,
    output rx_entry_t head,
    output logic      empty,
    output logic      full,
    output logic      ovr
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0] CNT_FULL = (AW + 1)'(DEPTH);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   cnt;
    logic          do_pop, do_push;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
        return (p == '0) ? AW'(DEPTH - 1) : p - 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_FULL);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign ovr     = push && !do_push;
    assign head    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_entry;
        if (ovr)     mem[ptr_dec(wr_ptr)].oe <= 1'b1;
    end
endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
    import uart_rx_tagged_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick16,
    input  logic        rx_in,
    input  logic [1:0]  cfg_len,
    input  logic        cfg_par_en,
    input  logic        cfg_par_odd,
    input  logic        rd_en,
    input  logic        err_clr,
    output logic [11:0] rd_data,
    output logic        rx_empty,
    output logic        rx_full,
    output logic [3:0]  err_sticky
);
    logic      rx_s;
    logic      fr_push;
    rx_entry_t fr_entry;
    rx_entry_t q_head;
    logic      q_ovr;
    logic [3:0] set_bits;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rx_s)
    );

    uart_rx_frame u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .push(fr_push), .entry(fr_entry)
    );

    uart_rx_queue #(.DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(fr_push), .push_entry(fr_entry),
        .pop(rd_en), .head(q_head), .empty(rx_empty), .full(rx_full), .ovr(q_ovr)
    );

    assign rd_data  = q_head;
    assign set_bits = {q_ovr, fr_push & fr_entry.be, fr_push & fr_entry.pe, fr_push & fr_entry.fe};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       err_sticky <= '0;
        else if (err_clr) err_sticky <= set_bits;
        else              err_sticky <= err_sticky | set_bits;
    end
endmodule

// File: rtl/uart_rx_tagged_chk.sv
module uart_rx_tagged_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic        err_clr,
    input logic        rx_empty,
    input logic        rx_full,
    input logic [3:0]  err_sticky,
    input logic        fr_push,
    input logic [11:0] fr_entry,
    input logic        q_ovr
);
    // R2
    full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !rx_empty);

    // R8
    overrun_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && fr_push && !rd_en) |=> rx_full);

    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_ovr |=> err_sticky[3]);

    // R7
    break_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_push && fr_entry[10]) |-> (fr_entry[7:0] == 8'h00 && !fr_entry[9] && !fr_entry[8]));

    // R9
    sticky_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((err_sticky & $past(err_sticky)) == $past(err_sticky)));

    // R10
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !fr_push && !q_ovr) |=> (err_sticky == 4'h0));

    // R11
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_empty && !fr_push) |=> rx_empty);
endmodule

bind uart_rx_tagged uart_rx_tagged_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .err_clr(err_clr),
    .rx_empty(rx_empty), .rx_full(rx_full), .err_sticky(err_sticky),
    .fr_push(fr_push), .fr_entry(fr_entry), .q_ovr(q_ovr)
);

// File: tb/uart_rx_tagged_tb.sv
module uart_rx_tagged_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick16 = 1'b0;
    logic        rx_in = 1'b1;
    logic [1:0]  cfg_len = 2'd3;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_odd = 1'b0;
    logic        rd_en = 1'b0;
    logic        err_clr = 1'b0;
    logic [11:0] rd_data;
    logic        rx_empty, rx_full;
    logic [3:0]  err_sticky;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam int BITCLK = 32;  // tick every second clock, 16 ticks per bit

    uart_rx_tagged u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rd_en(rd_en), .err_clr(err_clr), .rd_data(rd_data),
        .rx_empty(rx_empty), .rx_full(rx_full), .err_sticky(err_sticky)
    );

    always #2 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            tick16 = ~tick16;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input bit b);
        rx_in = b;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                              input bit podd, input bit bad_par, input bit stop);
        logic [7:0] dm;
        dm = d & 8'((1 << nb) - 1);
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) send_bit(dm[i]);
        if (pen) send_bit((^dm) ^ podd ^ bad_par);
        send_bit(stop);
        rx_in = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
    endtask

    task automatic pop_chk(input string tag, input int exp);
        check(tag, int'(rd_data), exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic clear_sticky();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] l, input bit pen, input bit podd);
        cfg_len = l; cfg_par_en = pen; cfg_par_odd = podd;
    endtask

    task automatic t_reset();
        check("R12 empty", int'(rx_empty), 1);
        check("R12 full", int'(rx_full), 0);
        check("R12 sticky", int'(err_sticky), 0);
        check("R12 rd_data", int'(rd_data), 0);
    endtask

    task automatic t_basic_order();
        set_cfg(2'd3, 1'b0, 1'b0);
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;   // pop on empty (R11)
        check("R11 empty pop", int'(rx_empty), 1);
        send_frame(8'hA5, 8, 0, 0, 0, 1);
        send_frame(8'h3C, 8, 0, 0, 0, 1);
        check("R2 not empty", int'(rx_empty), 0);
        pop_chk("R1 first entry", 12'h0A5);
        pop_chk("R11 second entry", 12'h03C);
        check("R2 empty again", int'(rx_empty), 1);
        check("R11 rd_data when empty", int'(rd_data), 0);
    endtask

    task automatic t_lengths();
        set_cfg(2'd0, 1'b0, 1'b0);
        send_frame(8'hFF, 5, 0, 0, 0, 1);
        pop_chk("R4 5-bit", 12'h01F);
        set_cfg(2'd1, 1'b0, 1'b0);
        send_frame(8'h2D, 6, 0, 0, 0, 1);
        pop_chk("R4 6-bit", 12'h02D);
        set_cfg(2'd2, 1'b1, 1'b0);
        send_frame(8'h41, 7, 1, 0, 0, 1);
        pop_chk("R4 7-bit even parity ok", 12'h041);
        set_cfg(2'd3, 1'b0, 1'b0);
    endtask

    task automatic t_parity();
        clear_sticky();
        set_cfg(2'd3, 1'b1, 1'b1);
        send_frame(8'h07, 8, 1, 1, 0, 1);
        pop_chk("R5 odd parity ok", 12'h007);
        check("R9 no parity sticky", int'(err_sticky), 0);
        set_cfg(2'd3, 1'b1, 1'b0);
        send_frame(8'h13, 8, 1, 0, 1, 1);
        pop_chk("R5 even parity error", 12'h213);
        check("R9 parity sticky", int'(err_sticky), 4'b0010);
        set_cfg(2'd3, 1'b0, 1'b0);
    endtask

    task automatic t_framing();
        clear_sticky();
        check("R10 cleared", int'(err_sticky), 0);
        send_frame(8'h55, 8, 0, 0, 0, 0);
        pop_chk("R6 framing", 12'h155);
        check("R9 framing sticky", int'(err_sticky), 4'b0001);
    endtask

    task automatic t_break();
        clear_sticky();
        rx_in = 1'b0;
        repeat (14 * BITCLK) @(negedge clk);
        check("R7 single entry while low", int'(rx_empty), 0);
        rx_in = 1'b1;
        repeat (3 * BITCLK) @(negedge clk);
        pop_chk("R7 break entry", 12'h400);
        check("R7 only one entry", int'(rx_empty), 1);
        check("R9 break sticky", int'(err_sticky), 4'b0100);
        send_frame(8'h5A, 8, 0, 0, 0, 1);
        pop_chk("R7 normal after break", 12'h05A);
    endtask

    task automatic t_false_start();
        rx_in = 1'b0;
        repeat (6) @(negedge clk);
        rx_in = 1'b1;
        repeat (3 * BITCLK) @(negedge clk);
        check("R3 glitch ignored", int'(rx_empty), 1);
    endtask

    task automatic t_overrun();
        clear_sticky();
        for (int i = 0; i < 17; i++) send_frame(8'(i), 8, 0, 0, 0, 1);
        check("R2 full", int'(rx_full), 1);
        check("R8 sticky overrun", int'(err_sticky), 4'b1000);
        for (int i = 0; i < 16; i++)
            pop_chk("R8 entry", (i == 15) ? (12'h800 | i) : i);
        check("R8 17th discarded", int'(rx_empty), 1);
        check("R2 not full", int'(rx_full), 0);
        clear_sticky();
        check("R10 clear after overrun", int'(err_sticky), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_order();
        t_lengths();
        t_parity();
        t_framing();
        t_break();
        t_false_start();
        t_overrun();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule